// File: doc/BRIEF.md
# Adaptive Scenario Budget Table

This block gives a frequency controller the cycle budget it should aim for while a given run-time situation executes. Every situation ID maps to one scenario, and every scenario holds one budget estimator. A lookup returns the budget of the scenario that the situation currently belongs to. The controller reports the slack it observed for each situation on a feedback port. Negative slack means the situation overran its budget.

Each situation keeps a short history of its overruns inside a fixed-length window. When one situation keeps overrunning, the block re-clusters it. It can move the situation to an existing scenario with a tighter budget, or open a new scenario for it. When the table is full, it lowers the tightest scenario's budget instead. Re-clustering takes a single cycle, runs alongside lookups and never stalls them. The initial mapping and the budgets are loaded through a write port.

Top module: `scenario_budget_table`

## Requirements
- R1: A lookup presented in one cycle returns, after the next clock edge, the budget of the scenario mapped to `lk_sit`. If a table write lands on that same edge, the lookup returns the value from before the write.
- R2: With `cfg_we` high and `cfg_is_budget`=1, the scenario at `cfg_idx` takes the budget `cfg_val` and becomes valid. With `cfg_is_budget`=0, the situation at `cfg_idx` is mapped to scenario `cfg_val[PW-1:0]`.
- R3: Reset clears `lk_budget` to 0, every budget and map entry to 0, every scenario to invalid, and every history.
- R4: Feedback with slack of zero or more is not counted and changes no budget or mapping.
- R5: A situation qualifies once its count of negative-slack reports in the window reaches `thresh`. A `thresh` of 0 disables re-clustering. Its new requirement is its scenario budget minus its largest overrun in the window, saturating at 0.
- R6: All histories clear every `WIN` cycles, so overruns that are spread across windows never trigger re-clustering.
- R7: If other valid scenarios have a budget no larger than the requirement, the situation moves to the one with the largest such budget. Ties go to the lowest index.
- R8: Otherwise, if an invalid scenario exists, the lowest-indexed one becomes valid with the requirement as its budget, and the situation moves to it.
- R9: Otherwise the valid scenario with the smallest budget (lowest index on ties) has its budget lowered to the requirement, and the situation moves to it.
- R10: At most one situation is re-clustered per cycle. The winner is the qualifying situation with the largest accumulated overrun; ties go to the lowest ID.
- R11: A re-clustered situation's history is cleared, so it does not re-cluster again without new overruns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh | input | CW | Overrun count that qualifies a situation (0 disables) |
| cfg_we | input | 1 | Table write strobe |
| cfg_is_budget | input | 1 | 1: write scenario budget, 0: write situation map |
| cfg_idx | input | AW | Scenario or situation index being written |
| cfg_val | input | BW | Budget value, or scenario number in low bits |
| lk_sit | input | SW | Situation ID to look up |
| lk_budget | output | BW | Budget for the previous cycle's lookup |
| fb_valid | input | 1 | Feedback strobe |
| fb_sit | input | SW | Situation the feedback refers to |
| fb_slack | input | BW+1 | Signed observed slack, negative for overrun |

## Verification
The hardest situation to reach from the ports is two situations qualifying on the same edge, because each one normally re-clusters the cycle after its own threshold is met. The bench holds `thresh` high while both situations build up overruns, then lowers it in a single cycle. The first winner takes the only suitable new scenario, and the second situation then fits into that scenario. So the second situation's budget shows which winner went first. Window expiry is covered by spreading two overruns across a window boundary and confirming that nothing moves until a further overrun inside the new window.

// File: rtl/scenario_budget_table.sv
module scenario_budget_table #(
  parameter int NSIT = 32,
  parameter int NSCN = 8,
  parameter int BW   = 16,
  parameter int CW   = 4,
  parameter int WIN  = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        thresh,
  input  logic                 cfg_we,
  input  logic                 cfg_is_budget,
  input  logic [((($clog2(NSIT))>($clog2(NSCN)))?($clog2(NSIT)):($clog2(NSCN)))-1:0] cfg_idx,
  input  logic [BW-1:0]        cfg_val,
  input  logic [$clog2(NSIT)-1:0] lk_sit,
  output logic [BW-1:0]        lk_budget,
  input  logic                 fb_valid,
  input  logic [$clog2(NSIT)-1:0] fb_sit,
  input  logic signed [BW:0]   fb_slack
);
  localparam int SW = $clog2(NSIT);
  localparam int PW = $clog2(NSCN);
  localparam int AW = (SW > PW) ? SW : PW;
  localparam int AC = BW + CW;
  localparam int WW = $clog2(WIN);

  logic [PW-1:0] smap [NSIT];
  logic [BW-1:0] bud  [NSCN];
  logic [NSCN-1:0] vld;
  logic [CW-1:0] hcnt [NSIT];
  logic [AC-1:0] hacc [NSIT];
  logic [BW-1:0] hmax [NSIT];
  logic [WW-1:0] wcnt;

  wire win_end = (wcnt == WW'(WIN - 1));

  // overrun magnitude of the incoming report
  logic [BW:0] neg_mag;
  logic [BW-1:0] ovr;
  logic fb_neg;
  assign fb_neg  = fb_valid && (fb_slack < 0);
  assign neg_mag = -fb_slack;
  assign ovr     = neg_mag[BW] ? '1 : neg_mag[BW-1:0];

  logic [AC:0] acc_sum;
  assign acc_sum = {1'b0, hacc[fb_sit]} + {{(AC-BW+1){1'b0}}, ovr};

  // winner selection
  logic rc_fire;
  logic [SW-1:0] rc_sit;
  logic [AC-1:0] rc_best;
  always_comb begin
    rc_fire = 1'b0;
    rc_sit  = '0;
    rc_best = '0;
    for (int i = 0; i < NSIT; i++) begin
      if (thresh != '0 && hcnt[i] >= thresh && (!rc_fire || hacc[i] > rc_best)) begin
        rc_fire = 1'b1;
        rc_sit  = SW'(i);
        rc_best = hacc[i];
      end
    end
  end

  logic [PW-1:0] rc_src;
  logic [BW-1:0] rc_req;
  assign rc_src = smap[rc_sit];
  assign rc_req = (bud[rc_src] > hmax[rc_sit]) ? bud[rc_src] - hmax[rc_sit] : '0;

  // destination search
  logic fit_ok, free_ok, t_ok;
  logic [PW-1:0] fit_idx, free_idx, t_idx;
  logic [BW-1:0] fit_bud, t_bud;
  always_comb begin
    fit_ok = 1'b0; fit_idx = '0; fit_bud = '0;
    free_ok = 1'b0; free_idx = '0;
    t_ok = 1'b0; t_idx = '0; t_bud = '0;
    for (int j = 0; j < NSCN; j++) begin
      if (vld[j] && PW'(j) != rc_src && bud[j] <= rc_req && (!fit_ok || bud[j] > fit_bud)) begin
        fit_ok = 1'b1; fit_idx = PW'(j); fit_bud = bud[j];
      end
      if (!vld[j] && !free_ok) begin
        free_ok = 1'b1; free_idx = PW'(j);
      end
      if (vld[j] && (!t_ok || bud[j] < t_bud)) begin
        t_ok = 1'b1; t_idx = PW'(j); t_bud = bud[j];
      end
    end
  end

  logic [PW-1:0] rc_dst;
  assign rc_dst = fit_ok ? fit_idx : (free_ok ? free_idx : t_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_budget <= '0;
      wcnt <= '0;
      vld <= '0;
      for (int i = 0; i < NSIT; i++) begin
        smap[i] <= '0; hcnt[i] <= '0; hacc[i] <= '0; hmax[i] <= '0;
      end
      for (int j = 0; j < NSCN; j++) bud[j] <= '0;
    end else begin
      lk_budget <= bud[smap[lk_sit]];
      wcnt <= win_end ? '0 : wcnt + 1'b1;

      if (win_end) begin
        for (int i = 0; i < NSIT; i++) begin
          hcnt[i] <= '0; hacc[i] <= '0; hmax[i] <= '0;
        end
      end else begin
        if (fb_neg) begin
          if (hcnt[fb_sit] != '1) hcnt[fb_sit] <= hcnt[fb_sit] + 1'b1;
          hacc[fb_sit] <= acc_sum[AC] ? '1 : acc_sum[AC-1:0];
          if (ovr > hmax[fb_sit]) hmax[fb_sit] <= ovr;
        end
        if (rc_fire) begin
          hcnt[rc_sit] <= '0; hacc[rc_sit] <= '0; hmax[rc_sit] <= '0;
        end
      end

      if (rc_fire) begin
        smap[rc_sit] <= rc_dst;
        if (!fit_ok) begin
          bud[rc_dst] <= rc_req;
          vld[rc_dst] <= 1'b1;
        end
      end

      if (cfg_we) begin
        if (cfg_is_budget) begin
          bud[cfg_idx[PW-1:0]] <= cfg_val;
          vld[cfg_idx[PW-1:0]] <= 1'b1;
        end else begin
          smap[cfg_idx[SW-1:0]] <= cfg_val[PW-1:0];
        end
      end
    end
  end

  AST_CFG_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_is_budget) |=> vld[$past(cfg_idx[PW-1:0])]); // R2
  AST_WIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> !rc_fire); // R6
  AST_DST_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_fire && !cfg_we) |=> bud[$past(rc_dst)] <= $past(rc_req)); // R7
  AST_ALLOC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $countones(vld) <= $countones($past(vld)) + 1); // R8
  AST_HIST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rc_fire |=> hcnt[$past(rc_sit)] == '0); // R11

  logic unused_ok;
  assign unused_ok = &{1'b0, cfg_idx[AW-1:0]};
endmodule

// File: tb/scenario_budget_table_tb.sv
module scenario_budget_table_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSIT = 32, NSCN = 8, BW = 16, CW = 4, WIN = 256;
  localparam int SW = $clog2(NSIT);
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic [CW-1:0] thresh;
  logic cfg_we, cfg_is_budget;
  logic [AW-1:0] cfg_idx;
  logic [BW-1:0] cfg_val;
  logic [SW-1:0] lk_sit;
  logic [BW-1:0] lk_budget;
  logic fb_valid;
  logic [SW-1:0] fb_sit;
  logic signed [BW:0] fb_slack;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scenario_budget_table #(.NSIT(NSIT), .NSCN(NSCN), .BW(BW), .CW(CW), .WIN(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .thresh(thresh), .cfg_we(cfg_we), .cfg_is_budget(cfg_is_budget),
    .cfg_idx(cfg_idx), .cfg_val(cfg_val), .lk_sit(lk_sit), .lk_budget(lk_budget),
    .fb_valid(fb_valid), .fb_sit(fb_sit), .fb_slack(fb_slack));

  // {situation, expected budget} after the standard load
  localparam logic [31:0] VEC [7] = '{
    {16'd0, 16'd1000}, {16'd1, 16'd800}, {16'd2, 16'd600}, {16'd3, 16'd1000},
    {16'd4, 16'd800}, {16'd5, 16'd600}, {16'd31, 16'd800}};

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [BW-1:0] act, input logic [BW-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; thresh = '0; cfg_we = 1'b0; cfg_is_budget = 1'b0; cfg_idx = '0;
    cfg_val = '0; lk_sit = '0; fb_valid = 1'b0; fb_sit = '0; fb_slack = '0;
    tick(3);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic isb, input int idx, input int val);
    cfg_we = 1'b1; cfg_is_budget = isb; cfg_idx = AW'(idx); cfg_val = BW'(val);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic fb(input int sit, input int slack);
    fb_valid = 1'b1; fb_sit = SW'(sit); fb_slack = (BW+1)'(slack);
    tick();
    fb_valid = 1'b0;
  endtask

  task automatic look(input int sit, input int exp, input string req);
    lk_sit = SW'(sit);
    tick();
    check(lk_budget, BW'(exp), req);
  endtask

  task automatic load_std();
    wr(1, 0, 1000); wr(1, 1, 800); wr(1, 2, 600);
    for (int i = 0; i < NSIT; i++) wr(0, i, i % 3);
  endtask

  task automatic load_full();
    for (int k = 0; k < NSCN; k++) wr(1, k, 1000 - 100 * k);
    for (int i = 0; i < NSIT; i++) wr(0, i, i % NSCN);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check(lk_budget, 0, "R3 reset output");
    look(5, 0, "R3 reset table");

    load_std();
    for (int v = 0; v < 7; v++) look(int'(VEC[v][31:16]), int'(VEC[v][15:0]), "R2 loaded map");

    // R1: write and lookup on the same edge
    lk_sit = 1; cfg_we = 1'b1; cfg_is_budget = 1'b1; cfg_idx = 1; cfg_val = 777;
    tick(); cfg_we = 1'b0;
    check(lk_budget, 800, "R1 old value on write edge");
    tick();
    check(lk_budget, 777, "R1 new value after write");

    // R4: non-negative slack ignored
    do_reset(); load_std(); thresh = 2;
    fb(4, 100); fb(4, 100); fb(4, 0); fb(4, 0); tick(3);
    look(4, 800, "R4 positive slack ignored");

    // R7 best fit, then R11 no repeat
    do_reset(); load_std(); thresh = 2;
    fb(0, -150); tick(3);
    look(0, 1000, "R6 single burst no change");
    fb(0, -150); tick(3);
    look(0, 800, "R7 moved to best fit");
    look(3, 1000, "R7 other member unchanged");
    tick(10);
    look(0, 800, "R11 history cleared");

    // R8 new scenario
    do_reset(); load_std(); thresh = 2;
    fb(2, -50); fb(2, -50); tick(3);
    look(2, 550, "R8 new scenario budget");
    look(5, 600, "R8 old scenario kept");

    // R9 full table
    do_reset(); load_full(); thresh = 2;
    fb(0, -900); fb(0, -900); tick(3);
    look(0, 100, "R9 moved to tightest");
    look(15, 100, "R9 tightest lowered");
    look(1, 900, "R9 others unchanged");

    // R6 window expiry
    do_reset(); load_std(); thresh = 2;
    fb(0, -150); tick(230);
    fb(0, -150); tick(3);
    look(0, 1000, "R6 window expiry");
    fb(0, -150); tick(3);
    look(0, 800, "R5 count within window");

    // R10 priority
    do_reset(); load_std(); thresh = 15;
    fb(0, -500); fb(1, -260); fb(0, -500); fb(1, -260);
    thresh = 2; tick(4);
    look(0, 500, "R10 winner got new scenario");
    look(1, 500, "R10 second fits winner's scenario");
    look(4, 800, "R10 shared scenario untouched");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule